// File: doc/BRIEF.md
# Interrupt and Reset Input Conditioner

This block sits in front of a CPU core and cleans up its four asynchronous control pins: a maskable interrupt request, a non-maskable interrupt request, a raw reset request and a wait-test input. Each pin passes through its own two-flop synchroniser before any logic looks at it. Nothing is buffered for the core. At each instruction boundary the block decides whether an interrupt is taken. It holds a take request with its type code until the core acknowledges it.

The maskable request is a level. It is looked at only in the cycle where the core flags the last clock of an instruction, and only if the core's interrupt-enable flag is set. The non-maskable request is edge-triggered: a rising edge is latched until the core services it, and it always wins over the maskable one. Its type code is fixed at 2. For a maskable take, the block reports the marker code `EXT_TYPE`, which means the core must fetch the real type in its own acknowledge cycles. Reset reaches the core only after the synchronised reset pin has stayed high for a minimum run of clocks. The stall flag tells a core that is running a wait instruction to keep idling while the test input is high.

All control and status pins are plain levels. The take request is a request/acknowledge pair: once raised, it is held, with a stable type, until the core pulses `take_ack_i`.

Top module: `irq_input_cond`

## Requirements
- R1: A take request is raised only at the clock edge that ends a cycle with `instr_end_i` high. A maskable request held high without `instr_end_i` raises nothing.
- R2: When `ie_flag_i` is low, the maskable request is ignored and no take request results.
- R3: A rising edge on `nmi_raw_i` is latched, whatever the state of `ie_flag_i`. At the next instruction boundary it raises a take request with `take_type_o` = 2. A level held high after the edge produces only one take.
- R4: When both requests are pending at a boundary, the non-maskable one is taken. A maskable take reports `take_type_o` = `EXT_TYPE` (default 8'hFF).
- R5: Once raised, `take_req_o` and `take_type_o` stay unchanged until `take_ack_i` is seen high. The request drops at the edge that samples the acknowledge.
- R6: Acknowledging a non-maskable take clears its latch. A new rising edge that arrives between the take and its acknowledge leaves the latch set, so it is taken again at a later boundary.
- R7: `core_reset_o` rises only after the synchronised reset input has been high for `RST_MIN` (default 4) consecutive clocks. Shorter pulses have no effect.
- R8: `core_reset_o` stays high while the reset input stays high. It falls once the low level has passed the synchroniser.
- R9: While `core_reset_o` is high, any take request and any latched non-maskable request are cleared.
- R10: `stall_o` is high exactly when `wait_active_i` is high and the synchronised test input is high. It is low when test is low or no wait instruction is active.
- R11: After `rst_ni` is released, all outputs are low, and `take_type_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low power-on reset of the block's own flops |
| intr_raw_i | input | 1 | Asynchronous maskable interrupt request, active high level |
| nmi_raw_i | input | 1 | Asynchronous non-maskable interrupt request, rising-edge triggered |
| reset_raw_i | input | 1 | Asynchronous reset request, active high |
| test_raw_i | input | 1 | Asynchronous wait-test input, high means keep waiting |
| instr_end_i | input | 1 | High in the last clock of each instruction |
| ie_flag_i | input | 1 | Interrupt-enable flag from the core |
| wait_active_i | input | 1 | High while the core executes a wait instruction |
| take_ack_i | input | 1 | Core acknowledges the pending take request |
| take_req_o | output | 1 | Interrupt must be taken |
| take_type_o | output | TYPE_W | Type code of the take: 2 for non-maskable, EXT_TYPE for maskable |
| core_reset_o | output | 1 | Qualified reset to the core |
| stall_o | output | 1 | Wait instruction must keep idling |

## Verification
The hardest case is a second non-maskable edge that lands while the first one is still in service. To reach it, the stimulus takes a non-maskable request and leaves it unacknowledged. It then drops the pin, waits for the low level to pass the synchroniser, and raises the pin again. Only after that does it acknowledge. The next boundary must then produce another type-2 take. A further case pulses reset for exactly one clock fewer than the minimum, then exactly the minimum, and watches `core_reset_o` on every cycle of each window.

// File: rtl/irq_input_cond_pkg.sv
package irq_input_cond_pkg;
  localparam int SIG_INTR = 0;
  localparam int SIG_NMI  = 1;
  localparam int SIG_RST  = 2;
  localparam int SIG_TEST = 3;
  localparam int NUM_SIG  = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MASK = 2'd1,
    SRC_NMI  = 2'd2
  } take_src_e;
endpackage

// File: rtl/icond_sync_bank.sv
module icond_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= async_i[b];
      else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/icond_reset_qual.sv
module icond_reset_qual #(
  parameter int RST_MIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_sync_i,
  output logic core_reset_o
);
  localparam int CNT_W = $clog2(RST_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(RST_MIN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_MIN - 1);

  logic [CNT_W-1:0] run_q;
  logic             qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (!rst_sync_i) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      if (run_q != CNT_TOP) run_q <= run_q + 1'b1;
      if (run_q == CNT_LAST) qual_q <= 1'b1;
    end
  end

  assign core_reset_o = qual_q;
endmodule

// File: rtl/icond_nmi_latch.sv
module icond_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_sync_i,
  input  logic in_service_i,
  input  logic service_done_i,
  input  logic core_reset_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  logic again_q;
  logic edge_w;

  assign edge_w = nmi_sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      again_q <= 1'b0;
    end else begin
      prev_q <= nmi_sync_i;
      if (core_reset_i) begin
        pend_q  <= 1'b0;
        again_q <= 1'b0;
      end else if (service_done_i) begin
        pend_q  <= again_q | edge_w;
        again_q <= 1'b0;
      end else begin
        if (edge_w) pend_q <= 1'b1;
        if (edge_w && in_service_i) again_q <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/icond_take_arb.sv
module icond_take_arb
  import irq_input_cond_pkg::*;
#(
  parameter int              TYPE_W   = 8,
  parameter logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2),
  parameter logic [TYPE_W-1:0] EXT_TYPE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_end_i,
  input  logic              ie_flag_i,
  input  logic              intr_sync_i,
  input  logic              nmi_pend_i,
  input  logic              ack_i,
  input  logic              core_reset_i,
  output logic              take_req_o,
  output logic [TYPE_W-1:0] take_type_o,
  output logic              nmi_in_service_o,
  output logic              nmi_done_o
);
  take_src_e   src_q;
  take_src_e   pick_w;
  logic        busy_w;

  assign busy_w = (src_q != SRC_NONE);

  always_comb begin
    pick_w = SRC_NONE;
    if (instr_end_i && !busy_w) begin
      if (nmi_pend_i) pick_w = SRC_NMI;
      else if (intr_sync_i && ie_flag_i) pick_w = SRC_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q       <= SRC_NONE;
      take_type_o <= '0;
    end else if (core_reset_i) begin
      src_q       <= SRC_NONE;
      take_type_o <= '0;
    end else if (busy_w) begin
      if (ack_i) src_q <= SRC_NONE;
    end else if (pick_w != SRC_NONE) begin
      src_q       <= pick_w;
      take_type_o <= (pick_w == SRC_NMI) ? NMI_TYPE : EXT_TYPE;
    end
  end

  assign take_req_o       = busy_w;
  assign nmi_in_service_o = (src_q == SRC_NMI);
  assign nmi_done_o       = (src_q == SRC_NMI) && ack_i;
endmodule

// File: rtl/irq_input_cond.sv
module irq_input_cond
  import irq_input_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_MIN     = 4,
  parameter int TYPE_W      = 8,
  parameter logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2),
  parameter logic [TYPE_W-1:0] EXT_TYPE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              intr_raw_i,
  input  logic              nmi_raw_i,
  input  logic              reset_raw_i,
  input  logic              test_raw_i,
  input  logic              instr_end_i,
  input  logic              ie_flag_i,
  input  logic              wait_active_i,
  input  logic              take_ack_i,
  output logic              take_req_o,
  output logic [TYPE_W-1:0] take_type_o,
  output logic              core_reset_o,
  output logic              stall_o
);
  logic [NUM_SIG-1:0] raw_w;
  logic [NUM_SIG-1:0] sync_w;
  logic nmi_pend_w;
  logic nmi_svc_w;
  logic nmi_done_w;

  always_comb begin
    raw_w           = '0;
    raw_w[SIG_INTR] = intr_raw_i;
    raw_w[SIG_NMI]  = nmi_raw_i;
    raw_w[SIG_RST]  = reset_raw_i;
    raw_w[SIG_TEST] = test_raw_i;
  end

  icond_sync_bank #(.WIDTH(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(raw_w), .sync_o(sync_w)
  );

  icond_reset_qual #(.RST_MIN(RST_MIN)) u_rstq (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_i(sync_w[SIG_RST]),
    .core_reset_o(core_reset_o)
  );

  icond_nmi_latch u_nmi (
    .clk_i(clk_i), .rst_ni(rst_ni), .nmi_sync_i(sync_w[SIG_NMI]),
    .in_service_i(nmi_svc_w), .service_done_i(nmi_done_w),
    .core_reset_i(core_reset_o), .pend_o(nmi_pend_w)
  );

  icond_take_arb #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE), .EXT_TYPE(EXT_TYPE)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_end_i(instr_end_i),
    .ie_flag_i(ie_flag_i), .intr_sync_i(sync_w[SIG_INTR]),
    .nmi_pend_i(nmi_pend_w), .ack_i(take_ack_i), .core_reset_i(core_reset_o),
    .take_req_o(take_req_o), .take_type_o(take_type_o),
    .nmi_in_service_o(nmi_svc_w), .nmi_done_o(nmi_done_w)
  );

  assign stall_o = wait_active_i & sync_w[SIG_TEST];
endmodule

// File: rtl/irq_input_cond_chk.sv
module irq_input_cond_chk #(
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] EXT_TYPE = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_end_i,
  input logic              ie_flag_i,
  input logic              wait_active_i,
  input logic              take_ack_i,
  input logic              take_req_o,
  input logic [TYPE_W-1:0] take_type_o,
  input logic              core_reset_o,
  input logic              stall_o
);
  AST_REQ_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_req_o) |-> $past(instr_end_i)); // R1
  AST_MASKED_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(take_req_o) && take_type_o == EXT_TYPE) |-> $past(ie_flag_i)); // R2
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_req_o && !take_ack_i && !core_reset_o) |=> (take_req_o && $stable(take_type_o))); // R5
  AST_REQ_DROP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_req_o && take_ack_i) |=> !take_req_o); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_o |=> !take_req_o); // R9
  AST_STALL_NEEDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> wait_active_i); // R10
endmodule

bind irq_input_cond irq_input_cond_chk #(.TYPE_W(TYPE_W), .EXT_TYPE(EXT_TYPE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_end_i(instr_end_i), .ie_flag_i(ie_flag_i),
  .wait_active_i(wait_active_i), .take_ack_i(take_ack_i), .take_req_o(take_req_o),
  .take_type_o(take_type_o), .core_reset_o(core_reset_o), .stall_o(stall_o)
);

// File: tb/irq_input_cond_tb.sv
module irq_input_cond_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam logic [7:0] T_NMI = 8'd2;
  localparam logic [7:0] T_EXT = 8'hFF;

  // {intr, ie, nmi_pulse, exp_req, exp_type}
  typedef struct packed {
    logic       intr;
    logic       ie;
    logic       nmi;
    logic       req;
    logic [7:0] typ;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, T_EXT},  // R4 maskable type
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 masked
    '{1'b0, 1'b1, 1'b1, 1'b1, T_NMI},  // R3 nmi
    '{1'b1, 1'b1, 1'b1, 1'b1, T_NMI},  // R4 priority
    '{1'b0, 1'b0, 1'b1, 1'b1, T_NMI}   // R3 unmaskable
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intr = 0, nmi = 0, rraw = 0, test = 0;
  logic iend = 0, ie = 0, wact = 0, ack = 0;
  logic req, crst, stall;
  logic [7:0] typ;
  int checks = 0, fails = 0;
  bit seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_input_cond u_dut (
    .clk_i(clk), .rst_ni(rst_n), .intr_raw_i(intr), .nmi_raw_i(nmi),
    .reset_raw_i(rraw), .test_raw_i(test), .instr_end_i(iend), .ie_flag_i(ie),
    .wait_active_i(wact), .take_ack_i(ack), .take_req_o(req),
    .take_type_o(typ), .core_reset_o(crst), .stall_o(stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (crst) seen = 1'b1;
    end
  endtask

  task automatic boundary();
    iend = 1'b1; tick(1); iend = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    chk("R11 req", req, 0); chk("R11 type", typ, 0);
    chk("R11 reset", crst, 0); chk("R11 stall", stall, 0);

    for (int v = 0; v < NVEC; v++) begin
      intr = VECS[v].intr; ie = VECS[v].ie;
      if (VECS[v].nmi) nmi = 1'b1;
      tick(5);
      boundary();
      chk($sformatf("R3/R4 vec%0d req", v), req, VECS[v].req);
      if (VECS[v].req) begin
        chk($sformatf("R4 vec%0d type", v), typ, VECS[v].typ);
        tick(3);
        chk($sformatf("R5 vec%0d held", v), {req, typ}, {1'b1, VECS[v].typ});
        do_ack();
        chk($sformatf("R5 vec%0d drop", v), req, 0);
      end
      intr = 1'b0; nmi = 1'b0; ie = 1'b0;
      tick(4);
    end

    // R1: maskable level without boundary
    intr = 1'b1; ie = 1'b1; tick(8);
    chk("R1 no boundary", req, 0);
    intr = 1'b0; tick(4);

    // R3: level held high gives one take only
    nmi = 1'b1; tick(5); boundary();
    chk("R3 first take", req, 1);
    do_ack(); tick(3); boundary();
    chk("R3 held level no retake", req, 0);
    nmi = 1'b0; tick(4);

    // R6: new edge during service
    nmi = 1'b1; tick(5); boundary();
    chk("R6 take", {req, typ}, {1'b1, T_NMI});
    nmi = 1'b0; tick(4); nmi = 1'b1; tick(5);
    do_ack(); tick(2); boundary();
    chk("R6 retake", {req, typ}, {1'b1, T_NMI});
    do_ack(); nmi = 1'b0; tick(4); boundary();
    chk("R6 latch cleared", req, 0);

    // R7: short pulse ignored, minimum pulse accepted
    seen = 1'b0; rraw = 1'b1; tick(3); rraw = 1'b0; tick(6);
    chk("R7 short pulse", seen, 0);
    seen = 1'b0; rraw = 1'b1; tick(4); rraw = 1'b0; tick(6);
    chk("R7 min pulse", seen, 1);
    chk("R8 released", crst, 0);

    // R8/R9: long reset clears pending nmi and request
    nmi = 1'b1; tick(5); boundary();
    chk("R9 pre req", req, 1);
    rraw = 1'b1; tick(10);
    chk("R8 held", crst, 1);
    chk("R9 req cleared", req, 0);
    rraw = 1'b0; tick(3);
    chk("R8 drop", crst, 0);
    boundary();
    chk("R9 nmi latch cleared", req, 0);
    nmi = 1'b0; tick(3);

    // R10: stall
    wact = 1'b1; test = 1'b1; tick(3);
    chk("R10 stall on", stall, 1);
    test = 1'b0; tick(3);
    chk("R10 test low", stall, 0);
    wact = 1'b0; test = 1'b1; tick(3);
    chk("R10 no wait", stall, 0);
    test = 1'b0; tick(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule